// File: doc/BRIEF.md
# Flash Error Tally

This block checks the data read back from a non-volatile memory page against the pseudo-random pattern that was written there. Each test iteration erases the block, writes pseudo-random words, then reads them back. The block holds a 16-bit linear feedback shift register. It reseeds that register from a base seed and the running iteration number at the start of the write pass and again at the start of the read pass. The read pass therefore sees exactly the words that were written.

Every mismatched bit is sorted by its direction. A "plus" error is a bit that should be 0 and reads as 1. A "minus" error is a bit that should be 1 and reads as 0. Errors are also summed by page parity, with even-numbered and odd-numbered pages kept in separate totals. All four totals build up over a window of consecutive iterations. The window is 200 iterations in single-level mode and 50 iterations in multi-level mode. At the end of each window the block reports the totals for one cycle and starts again from zero. Totals saturate rather than wrap.

Top module: `flash_err_tally`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `res_valid` is 0 and all four result outputs are 0. `pat_word` then shows the low 8 bits of the seed for iteration 0.
- R2: The pattern register is 16 bits. It steps as `s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}`, and `pat_word` is `s[7:0]`. The seed is `base_seed XOR iteration_number`, with a result of zero replaced by 16'h0001.
- R3: The pattern register steps once in each cycle where `pat_next` or `rd_valid` is high. `pat_restart` reloads the seed and has priority over stepping. With none of the three high, `pat_word` holds.
- R4: Each read bit whose expected value is 0 and whose read value is 1 adds one to the plus total.
- R5: Each read bit whose expected value is 1 and whose read value is 0 adds one to the minus total.
- R6: `pat_restart` sets the page number to 0. A valid word with `rd_page_start` high begins the next page, except the first such word after the restart, which stays on page 0. Plus and minus errors on even pages add to the even total, and those on odd pages add to the odd total.
- R7: An iteration ends on a valid word with `rd_iter_end` high. When the window count is reached (WIN_SLC iterations with `mlc_mode` = 0, WIN_MLC with `mlc_mode` = 1; defaults 200 and 50), `res_valid` is high for exactly the next cycle. At that point the outputs hold totals that include the final word.
- R8: After a report all running totals restart from 0. The result outputs hold their values until the next report.
- R9: Each total stops at 2^CNT_W - 1 instead of wrapping.
- R10: The iteration number counts every completed iteration from reset. It does not clear at window ends, and it selects the seed used by every `pat_restart`.
- R11: Cycles with `rd_valid` low count nothing. Their page-start and iteration-end strobes are ignored, and they do not step the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_seed | input | 16 | Base seed mixed with the iteration number |
| mlc_mode | input | 1 | 1 selects the multi-level window length |
| pat_restart | input | 1 | Reload the pattern seed (start of write or read pass) |
| pat_next | input | 1 | Step the pattern during the write pass |
| pat_word | output | 8 | Current expected/write pattern word |
| rd_valid | input | 1 | Read word valid |
| rd_data | input | 8 | Read word |
| rd_page_start | input | 1 | Read word is the first of a page |
| rd_iter_end | input | 1 | Read word is the last of an iteration |
| res_valid | output | 1 | One-cycle window report strobe |
| res_plus | output | CNT_W | Plus-error total of the window |
| res_minus | output | CNT_W | Minus-error total of the window |
| res_even | output | CNT_W | Error total on even pages |
| res_odd | output | CNT_W | Error total on odd pages |

## Verification
A bad pattern register state shows on `pat_word` in the same cycle. It then distorts every count for the rest of that pass. A wrong iteration number shows at the next `pat_restart` as a wrong seed. A parity flag or an accumulator in error stays hidden until the window closes. The fault then appears as a misplaced split between the even and odd totals, or between the plus and minus totals, in the cycle after the last word of the window. A window counter in error shows as `res_valid` rising one or more iterations early or late.

// File: rtl/flt_pkg.sv
package flt_pkg;

    localparam int DATA_W  = 8;
    localparam int INC_W   = $clog2(DATA_W + 1);
    localparam int LFSR_W  = 16;
    localparam int N_TALLY = 4;

    localparam int IX_PLUS  = 0;
    localparam int IX_MINUS = 1;
    localparam int IX_EVEN  = 2;
    localparam int IX_ODD   = 3;

    typedef logic [LFSR_W-1:0] lfsr_t;

    typedef enum logic {
        PG_EVEN = 1'b0,
        PG_ODD  = 1'b1
    } pg_par_e;

    typedef struct packed {
        logic             valid;
        logic             iter_end;
        pg_par_e          par;
        logic [INC_W-1:0] plus_n;
        logic [INC_W-1:0] minus_n;
    } cmp_ev_t;

    function automatic lfsr_t lfsr_adv(input lfsr_t s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic lfsr_t seed_for(input lfsr_t base, input lfsr_t iter);
        lfsr_t t;
        t = base ^ iter;
        if (t == '0) t = lfsr_t'(1);
        return t;
    endfunction

    function automatic logic [INC_W-1:0] ones(input logic [DATA_W-1:0] v);
        logic [INC_W-1:0] n;
        n = '0;
        for (int i = 0; i < DATA_W; i++) n = n + INC_W'(v[i]);
        return n;
    endfunction

endpackage

// File: rtl/flt_pattern_gen.sv
module flt_pattern_gen
    import flt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  lfsr_t             base_seed,
    input  lfsr_t             iter_idx,
    input  logic              restart,
    input  logic              advance,
    output logic [DATA_W-1:0] word
);

    lfsr_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= seed_for(base_seed, '0);
        end else if (restart) begin
            state_q <= seed_for(base_seed, iter_idx);
        end else if (advance) begin
            state_q <= lfsr_adv(state_q);
        end
    end

    assign word = state_q[DATA_W-1:0];

endmodule

// File: rtl/flt_word_compare.sv
module flt_word_compare
    import flt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_page_start,
    input  logic              rd_iter_end,
    input  logic [DATA_W-1:0] exp_word,
    output cmp_ev_t           ev
);

    pg_par_e par_q;
    logic    fresh_q;
    pg_par_e cur_par;
    logic    new_page;

    assign new_page = rd_valid && rd_page_start;

    always_comb begin
        cur_par = par_q;
        if (new_page && !fresh_q) cur_par = pg_par_e'(~par_q);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            par_q   <= PG_EVEN;
            fresh_q <= 1'b1;
        end else if (new_page) begin
            par_q   <= cur_par;
            fresh_q <= 1'b0;
        end
    end

    always_comb begin
        ev.valid    = rd_valid;
        ev.iter_end = rd_valid && rd_iter_end;
        ev.par      = cur_par;
        ev.plus_n   = ones(rd_data & ~exp_word);
        ev.minus_n  = ones(exp_word & ~rd_data);
    end

endmodule

// File: rtl/flt_tally.sv
module flt_tally
    import flt_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int WIN_SLC = 200,
    parameter int WIN_MLC = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mlc_mode,
    input  cmp_ev_t          ev,
    output logic             res_valid,
    output logic [CNT_W-1:0] res_plus,
    output logic [CNT_W-1:0] res_minus,
    output logic [CNT_W-1:0] res_even,
    output logic [CNT_W-1:0] res_odd,
    output logic [CNT_W-1:0] acc_plus,
    output logic [CNT_W-1:0] acc_minus,
    output lfsr_t            iter_idx
);

    localparam int WIN_MAX = (WIN_SLC > WIN_MLC) ? WIN_SLC : WIN_MLC;
    localparam int WC_W    = $clog2(WIN_MAX + 1);

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [INC_W:0]   b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + (CNT_W + 1)'(b);
        return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
    endfunction

    logic [INC_W:0]    inc     [N_TALLY];
    logic [CNT_W-1:0]  acc_bus [N_TALLY];
    logic [CNT_W-1:0]  res_bus [N_TALLY];
    logic [INC_W:0]    tot;
    logic [WC_W-1:0]   win_cnt_q;
    logic [WC_W-1:0]   win_lim;
    logic              win_done;
    logic              res_valid_q;
    lfsr_t             iter_q;

    always_comb begin
        tot            = {1'b0, ev.plus_n} + {1'b0, ev.minus_n};
        inc[IX_PLUS]   = ev.valid ? {1'b0, ev.plus_n}  : '0;
        inc[IX_MINUS]  = ev.valid ? {1'b0, ev.minus_n} : '0;
        inc[IX_EVEN]   = (ev.valid && ev.par == PG_EVEN) ? tot : '0;
        inc[IX_ODD]    = (ev.valid && ev.par == PG_ODD)  ? tot : '0;
    end

    assign win_lim  = mlc_mode ? WC_W'(WIN_MLC) : WC_W'(WIN_SLC);
    assign win_done = ev.iter_end &&
                      ((WC_W + 1)'(win_cnt_q) + 1'b1 >= (WC_W + 1)'(win_lim));

    for (genvar k = 0; k < N_TALLY; k++) begin : g_cnt
        logic [CNT_W-1:0] acc_r;
        logic [CNT_W-1:0] res_r;
        logic [CNT_W-1:0] nxt;

        assign nxt = sat_add(acc_r, inc[k]);

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_r <= '0;
                res_r <= '0;
            end else if (win_done) begin
                acc_r <= '0;
                res_r <= nxt;
            end else begin
                acc_r <= nxt;
            end
        end

        assign acc_bus[k] = acc_r;
        assign res_bus[k] = res_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt_q   <= '0;
            res_valid_q <= 1'b0;
            iter_q      <= '0;
        end else begin
            res_valid_q <= win_done;
            if (ev.iter_end) iter_q <= iter_q + 1'b1;
            if (win_done)          win_cnt_q <= '0;
            else if (ev.iter_end)  win_cnt_q <= win_cnt_q + 1'b1;
        end
    end

    assign res_valid = res_valid_q;
    assign res_plus  = res_bus[IX_PLUS];
    assign res_minus = res_bus[IX_MINUS];
    assign res_even  = res_bus[IX_EVEN];
    assign res_odd   = res_bus[IX_ODD];
    assign acc_plus  = acc_bus[IX_PLUS];
    assign acc_minus = acc_bus[IX_MINUS];
    assign iter_idx  = iter_q;

endmodule

// File: rtl/flash_err_tally.sv
module flash_err_tally
    import flt_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int WIN_SLC = 200,
    parameter int WIN_MLC = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LFSR_W-1:0] base_seed,
    input  logic              mlc_mode,
    input  logic              pat_restart,
    input  logic              pat_next,
    output logic [DATA_W-1:0] pat_word,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_page_start,
    input  logic              rd_iter_end,
    output logic              res_valid,
    output logic [CNT_W-1:0]  res_plus,
    output logic [CNT_W-1:0]  res_minus,
    output logic [CNT_W-1:0]  res_even,
    output logic [CNT_W-1:0]  res_odd
);

    cmp_ev_t          ev;
    lfsr_t            iter_idx;
    logic [CNT_W-1:0] acc_plus;
    logic [CNT_W-1:0] acc_minus;

    flt_pattern_gen u_pat (
        .clk       (clk),
        .rst       (rst),
        .base_seed (base_seed),
        .iter_idx  (iter_idx),
        .restart   (pat_restart),
        .advance   (pat_next || rd_valid),
        .word      (pat_word)
    );

    flt_word_compare u_cmp (
        .clk           (clk),
        .rst           (rst),
        .restart       (pat_restart),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_page_start (rd_page_start),
        .rd_iter_end   (rd_iter_end),
        .exp_word      (pat_word),
        .ev            (ev)
    );

    flt_tally #(
        .CNT_W   (CNT_W),
        .WIN_SLC (WIN_SLC),
        .WIN_MLC (WIN_MLC)
    ) u_tally (
        .clk       (clk),
        .rst       (rst),
        .mlc_mode  (mlc_mode),
        .ev        (ev),
        .res_valid (res_valid),
        .res_plus  (res_plus),
        .res_minus (res_minus),
        .res_even  (res_even),
        .res_odd   (res_odd),
        .acc_plus  (acc_plus),
        .acc_minus (acc_minus),
        .iter_idx  (iter_idx)
    );

endmodule

// File: rtl/flt_tally_chk.sv
module flt_tally_chk #(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              pat_restart,
    input logic              pat_next,
    input logic              rd_valid,
    input logic [DATA_W-1:0] pat_word,
    input logic              res_valid,
    input logic [CNT_W-1:0]  res_plus,
    input logic [CNT_W-1:0]  res_minus,
    input logic [CNT_W-1:0]  res_even,
    input logic [CNT_W-1:0]  res_odd,
    input logic [CNT_W-1:0]  acc_plus,
    input logic [CNT_W-1:0]  acc_minus
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!res_valid && res_plus == '0 && res_minus == '0 &&
                        res_even == '0 && res_odd == '0));

    // R3
    pat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pat_restart && !pat_next && !rd_valid) |=> $stable(pat_word));

    // R7
    res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    // R8
    clear_after_report_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (acc_plus == '0 && acc_minus == '0));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> (res_valid || ($stable(res_plus) && $stable(res_minus) &&
                                      $stable(res_even) && $stable(res_odd))));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> (res_valid || (acc_plus >= $past(acc_plus) &&
                                      acc_minus >= $past(acc_minus))));

endmodule

bind flash_err_tally flt_tally_chk #(
    .CNT_W  (CNT_W),
    .DATA_W (flt_pkg::DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pat_restart (pat_restart),
    .pat_next    (pat_next),
    .rd_valid    (rd_valid),
    .pat_word    (pat_word),
    .res_valid   (res_valid),
    .res_plus    (res_plus),
    .res_minus   (res_minus),
    .res_even    (res_even),
    .res_odd     (res_odd),
    .acc_plus    (acc_plus),
    .acc_minus   (acc_minus)
);

// File: tb/tb_flash_err_tally.sv
module tb_flash_err_tally;

    localparam int CW   = 8;
    localparam int WS   = 3;
    localparam int WM   = 2;
    localparam int SATV = (1 << CW) - 1;
    localparam logic [15:0] BASE = 16'hACE1;

    // {odd_only, pages, words_per_page, xor_mask}; entries 6..7 run in multi-level mode
    localparam logic [16:0] VEC [8] = '{
        {1'b0, 4'd2, 4'd3, 8'h01},
        {1'b1, 4'd2, 4'd2, 8'h80},
        {1'b0, 4'd1, 4'd4, 8'h00},
        {1'b0, 4'd3, 4'd2, 8'hA5},
        {1'b1, 4'd2, 4'd3, 8'h3C},
        {1'b0, 4'd1, 4'd1, 8'hFF},
        {1'b0, 4'd2, 4'd2, 8'h0F},
        {1'b1, 4'd3, 4'd1, 8'hF0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   base_seed = BASE;
    logic          mlc_mode = 1'b0;
    logic          pat_restart = 1'b0;
    logic          pat_next = 1'b0;
    logic [7:0]    pat_word;
    logic          rd_valid = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          rd_page_start = 1'b0;
    logic          rd_iter_end = 1'b0;
    logic          res_valid;
    logic [CW-1:0] res_plus, res_minus, res_even, res_odd;

    always #5 clk = ~clk;

    flash_err_tally #(.CNT_W(CW), .WIN_SLC(WS), .WIN_MLC(WM)) dut (
        .clk(clk), .rst(rst), .base_seed(base_seed), .mlc_mode(mlc_mode),
        .pat_restart(pat_restart), .pat_next(pat_next), .pat_word(pat_word),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_page_start(rd_page_start),
        .rd_iter_end(rd_iter_end), .res_valid(res_valid), .res_plus(res_plus),
        .res_minus(res_minus), .res_even(res_even), .res_odd(res_odd)
    );

    int n_chk = 0;
    int n_fail = 0;
    int m_iter = 0;
    int m_win = 0;
    int m_acc [4];
    logic [15:0] ms;

    function automatic logic [15:0] m_adv(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [15:0] m_seed(input int it);
        logic [15:0] t;
        t = BASE ^ 16'(it);
        if (t == 16'h0) t = 16'h0001;
        return t;
    endfunction

    function automatic int sat(input int v);
        return (v > SATV) ? SATV : v;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] d, input logic ps,
                         input logic ie, input logic pn, input logic pr);
        @(negedge clk);
        rd_valid = v; rd_data = d; rd_page_start = ps; rd_iter_end = ie;
        pat_next = pn; pat_restart = pr;
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run_iter(input bit odd_only, input int pages, input int words,
                            input logic [7:0] mask, input bit mlc);
        int pat_bad;
        int lim;
        logic [7:0] e, d;
        bit odd, last;
        pat_bad = 0;
        mlc_mode = mlc;
        // write pass
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        ms = m_seed(m_iter);
        for (int w = 0; w < pages * words; w++) begin
            @(negedge clk);
            if (pat_word !== ms[7:0]) pat_bad++;
            pat_restart = 1'b0; pat_next = 1'b1;
            ms = m_adv(ms);
        end
        // read pass
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        ms = m_seed(m_iter);
        for (int p = 0; p < pages; p++) begin
            for (int w = 0; w < words; w++) begin
                @(negedge clk);
                e = ms[7:0];
                if (pat_word !== e) pat_bad++;
                odd = p[0];
                d = (!odd_only || odd) ? (e ^ mask) : e;
                last = (p == pages - 1) && (w == words - 1);
                rd_valid = 1'b1; rd_data = d; rd_page_start = (w == 0);
                rd_iter_end = last; pat_next = 1'b0; pat_restart = 1'b0;
                ms = m_adv(ms);
                m_acc[0] = sat(m_acc[0] + $countones(d & ~e));
                m_acc[1] = sat(m_acc[1] + $countones(e & ~d));
                if (odd) m_acc[3] = sat(m_acc[3] + $countones(d ^ e));
                else     m_acc[2] = sat(m_acc[2] + $countones(d ^ e));
                // invalid cycle with strobes and junk data: must be ignored (R11)
                if (!last) drive(1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0);
            end
        end
        idle();
        chk("R2 R10 pattern word mismatches in iteration", pat_bad, 0);
        m_iter++;
        m_win++;
        lim = mlc ? WM : WS;
        if (m_win >= lim) begin
            chk("R7 res_valid at window end", int'(res_valid), 1);
            chk("R4 R11 plus total", int'(res_plus), m_acc[0]);
            chk("R5 R11 minus total", int'(res_minus), m_acc[1]);
            chk("R6 even page total", int'(res_even), m_acc[2]);
            chk("R6 odd page total", int'(res_odd), m_acc[3]);
            for (int k = 0; k < 4; k++) m_acc[k] = 0;
            m_win = 0;
        end else begin
            chk("R7 res_valid low inside window", int'(res_valid), 0);
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog R7 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [CW-1:0] held;
        for (int k = 0; k < 4; k++) m_acc[k] = 0;
        repeat (3) @(negedge clk);
        chk("R1 res_valid in reset", int'(res_valid), 0);
        chk("R1 res_plus in reset", int'(res_plus), 0);
        chk("R1 pattern seed after reset", int'(pat_word), int'(m_seed(0) & 16'hFF));
        rst = 1'b0;
        idle();
        chk("R1 res_odd after reset", int'(res_odd), 0);

        // restart then idle: word must hold at the seed
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        idle(); idle(); idle();
        chk("R3 pattern holds while idle", int'(pat_word), int'(m_seed(0) & 16'hFF));

        // table walk
        for (int i = 0; i < 8; i++) begin
            run_iter(VEC[i][16], int'(VEC[i][15:12]), int'(VEC[i][11:8]),
                     VEC[i][7:0], i >= 6);
            if (i == 2) begin
                held = res_plus;
                idle();
                chk("R8 res_valid one cycle only", int'(res_valid), 0);
                chk("R8 result held after report", int'(res_plus), int'(held));
            end
        end

        // saturation: every bit flipped on four pages of eight words, two iterations
        run_iter(1'b0, 4, 8, 8'hFF, 1'b1);
        run_iter(1'b0, 4, 8, 8'hFF, 1'b1);
        chk("R9 even total saturates", int'(res_even), SATV);

        // reset in the middle of a run returns the iteration number to 0
        rst = 1'b1;
        idle(); idle();
        rst = 1'b0;
        idle();
        chk("R1 R10 seed after mid-run reset", int'(pat_word), int'(m_seed(0) & 16'hFF));
        chk("R1 result cleared by reset", int'(res_plus), 0);
        m_iter = 0; m_win = 0;
        for (int k = 0; k < 4; k++) m_acc[k] = 0;
        run_iter(1'b0, 1, 3, 8'h11, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule